// File: doc/BRIEF.md
# Peripheral Request Router

This block sits between a set of peripheral request lines and a bank of DMA channels. Every request line has its own small routing entry holding an enable flag and a target channel index. While an entry is enabled and its request line is high, the request input of the target channel is raised in the same cycle. A channel's request is the OR of all enabled request lines that point at it.

Software programs the entries through a plain address/data port, with separate write and read strobes and a shared address. Request lines are split into two address windows. The first window covers lines 0 to 63 and the second covers lines from 64 upward. A read-only status word reports which channels currently see a routed request. Reads return data one cycle after the read strobe. Synchronisation of requests from foreign clock domains is done outside this block.

Top module: `dreq_router`

## Requirements
- R1: After reset every routing entry is disabled: no channel request is raised for any request pattern, and every routing entry reads as zero.
- R2: A routing entry stores write-data bit 7 as its enable flag and bits [4:0] as its channel index. A read returns those bits in the same positions, and all other bits read as zero. Read data appears on `rd_data` on the clock edge that samples `rd_en`.
- R3: The entry for request line n (n < 64) is at byte address 0x100 + 4*n. The entry for request line n (n >= 64) is at 0x1100 + 4*(n-64).
- R4: While request line n is high and its entry is enabled with channel index c, `chan_req[c]` is high in the same cycle, with no register in the path.
- R5: When several enabled entries name the same channel, that channel's request is the OR of their request lines.
- R6: A disabled entry never routes its request line, whatever its channel index holds. Writing zero to an entry removes its routing.
- R7: A read at address 0x0000 returns the channel request vector sampled at the read edge, with bit c for channel c. Writes to that address change nothing.
- R8: Any address that is misaligned, lies outside both windows, or names a request line at or above NUM_REQ reads as zero, and writes to it change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_in | input | NUM_REQ | Peripheral request lines |
| chan_req | output | NUM_CH | Request input to each DMA channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address for read or write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |

## Verification
Single request lines are driven one at a time against a known mapping, which separates a wrong channel index from a wrong enable flag. Pairs of lines aimed at one channel, including one line from each address window, expose a missing OR or a window decode that aliases the upper lines onto the lower ones. Wide random request vectors over randomly rewritten tables test the whole crossbar against a bench model. Reads at the status word, at misaligned and out-of-range offsets, and writes to those offsets show whether decode leaks into the table.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

  localparam int unsigned BUS_W      = 32;
  localparam int unsigned ADR_W      = 16;
  localparam int unsigned CH_FIELD_W = 5;
  localparam int unsigned EN_BIT     = 7;
  localparam int unsigned WIN_SPAN   = 64;
  localparam logic [7:0]  WIN_LO_PAGE = 8'h01;
  localparam logic [7:0]  WIN_HI_PAGE = 8'h11;
  localparam logic [ADR_W-1:0] STATUS_ADR = '0;

  typedef struct packed {
    logic                  en;
    logic [CH_FIELD_W-1:0] ch;
  } route_ent_t;

  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
  } adr_dec_t;

  function automatic adr_dec_t decode_entry(input logic [ADR_W-1:0] a,
                                            input int unsigned nreq);
    adr_dec_t    d;
    int unsigned n;
    d = '0;
    n = nreq;
    if (a[1:0] == 2'b00) begin
      if (a[15:8] == WIN_LO_PAGE)      n = int'(a[7:2]);
      else if (a[15:8] == WIN_HI_PAGE) n = WIN_SPAN + int'(a[7:2]);
    end
    if (n < nreq) begin
      d.hit = 1'b1;
      d.idx = n[7:0];
    end
    return d;
  endfunction

  function automatic route_ent_t unpack_entry(input logic [BUS_W-1:0] w);
    route_ent_t e;
    e.en = w[EN_BIT];
    e.ch = w[CH_FIELD_W-1:0];
    return e;
  endfunction

  function automatic logic [BUS_W-1:0] pack_entry(input route_ent_t e);
    logic [BUS_W-1:0] w;
    w = '0;
    w[EN_BIT] = e.en;
    w[CH_FIELD_W-1:0] = e.ch;
    return w;
  endfunction

endpackage

// File: rtl/dreq_router_regs.sv
module dreq_router_regs
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] addr,
  input  logic [BUS_W-1:0] wr_data,
  output route_ent_t       ents [NUM_REQ],
  output logic             sel_hit,
  output logic [7:0]       sel_idx,
  output logic             stat_sel
);

  adr_dec_t dec;

  assign dec      = decode_entry(addr, NUM_REQ);
  assign sel_hit  = dec.hit;
  assign sel_idx  = dec.idx;
  assign stat_sel = (addr == STATUS_ADR);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_ent
    logic wr_this;
    assign wr_this = wr_en && dec.hit && (dec.idx == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ents[g] <= '0;
      else if (wr_this) ents[g] <= unpack_entry(wr_data);
    end
  end

endmodule

// File: rtl/dreq_router_xbar.sv
module dreq_router_xbar
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic [NUM_REQ-1:0] req_in,
  input  route_ent_t         ents [NUM_REQ],
  output logic [NUM_CH-1:0]  chan_req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_REQ-1:0] hits;
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_rq
      assign hits[r] = req_in[r] & ents[r].en & (ents[r].ch == CH_FIELD_W'(c));
    end
    assign chan_req[c] = |hits;
  end

endmodule

// File: rtl/dreq_router_rdmux.sv
module dreq_router_rdmux
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              sel_hit,
  input  logic [7:0]        sel_idx,
  input  logic              stat_sel,
  input  route_ent_t        ents [NUM_REQ],
  input  logic [NUM_CH-1:0] chan_req,
  output logic [BUS_W-1:0]  rd_data
);

  logic [BUS_W-1:0] rd_next;

  always_comb begin
    if (stat_sel)     rd_next = BUS_W'(chan_req);
    else if (sel_hit) rd_next = pack_entry(ents[sel_idx]);
    else              rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_router_pkg::*;
#(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  chan_req,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADR_W-1:0]   addr,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [BUS_W-1:0]   rd_data
);

  route_ent_t ents [NUM_REQ];
  logic       sel_hit;
  logic [7:0] sel_idx;
  logic       stat_sel;

  dreq_router_regs #(.NUM_REQ(NUM_REQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ents(ents), .sel_hit(sel_hit), .sel_idx(sel_idx), .stat_sel(stat_sel)
  );

  dreq_router_xbar #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_xbar (
    .req_in(req_in), .ents(ents), .chan_req(chan_req)
  );

  dreq_router_rdmux #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel_hit(sel_hit),
    .sel_idx(sel_idx), .stat_sel(stat_sel), .ents(ents),
    .chan_req(chan_req), .rd_data(rd_data)
  );

endmodule

// File: rtl/dreq_router_chk.sv
module dreq_router_chk #(
  parameter int unsigned NUM_REQ = 80,
  parameter int unsigned NUM_CH  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_in,
  input logic [NUM_CH-1:0]  chan_req,
  input logic               rd_en,
  input logic [31:0]        rd_data,
  input logic               sel_hit,
  input logic               stat_sel
);

  AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_req) |-> (|req_in)); // R6

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_sel) |=> (rd_data == 32'($past(chan_req)))); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_hit && !stat_sel) |=> (rd_data == 32'd0)); // R8

  AST_ENTRY_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_hit) |=> (rd_data[31:8] == 24'd0 && rd_data[6:5] == 2'd0)); // R2

endmodule

bind dreq_router dreq_router_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .chan_req(chan_req),
  .rd_en(rd_en), .rd_data(rd_data), .sel_hit(sel_hit), .stat_sel(stat_sel)
);

// File: tb/dreq_router_bench.sv
module dreq_router_bench;
  localparam int NREQ = 80;
  localparam int NCH  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREQ-1:0] req_in = '0;
  logic [NCH-1:0]  chan_req;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0]     addr = '0;
  logic [31:0]     wr_data = '0, rd_data;

  int checks = 0, errors = 0;
  bit done = 0;
  bit         m_en [NREQ];
  logic [4:0] m_ch [NREQ];

  always #4 clk = ~clk;

  dreq_router u_dreq_router (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .chan_req(chan_req),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [15:0] slot_adr(int n);
    return (n < 64) ? 16'(32'h100 + 4*n) : 16'(32'h1100 + 4*(n-64));
  endfunction

  function automatic logic [NCH-1:0] model_route(logic [NREQ-1:0] rq);
    logic [NCH-1:0] v = '0;
    for (int r = 0; r < NREQ; r++) if (rq[r] && m_en[r]) v[m_ch[r]] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] model_word(int n);
    return {24'd0, m_en[n], 2'b00, m_ch[n]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    for (int r = 0; r < NREQ; r++)
      if (slot_adr(r) == a) begin m_en[r] = d[7]; m_ch[r] = d[4:0]; end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic drive_chk(string tag, logic [NREQ-1:0] rq);
    req_in = rq; #1;
    chk(tag, 32'(chan_req), 32'(model_route(rq)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [NREQ-1:0] rq;
    void'($urandom(32'h5EED));
    for (int r = 0; r < NREQ; r++) begin m_en[r] = 0; m_ch[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    req_in = '1; #1; chk("R1 no routing after reset", 32'(chan_req), 32'd0);
    rd(slot_adr(0), d);  chk("R1 entry 0 cleared", d, 32'd0);
    rd(slot_adr(79), d); chk("R1 entry 79 cleared", d, 32'd0);

    // R2: format and readback
    wr(slot_adr(3), 32'h0000_0085); rd(slot_adr(3), d); chk("R2 readback", d, 32'h85);
    wr(slot_adr(9), 32'hFFFF_FFE9); rd(slot_adr(9), d); chk("R2 masked bits", d, 32'h89);

    // R3: upper window addressing
    wr(16'h1108, 32'h8C);
    rd(slot_adr(66), d); chk("R3 upper window entry", d, 32'h8C);
    rd(slot_adr(2), d);  chk("R3 lower entry untouched", d, 32'h0);
    drive_chk("R3 line 66 to ch12", NREQ'(1) << 66);
    chk("R3 line 66 bit", 32'(chan_req), 32'h1000);

    // R4: single route
    drive_chk("R4 line 3 to ch5", NREQ'(1) << 3);
    chk("R4 ch5", 32'(chan_req), 32'h20);

    // R5: OR of two lines onto ch7
    wr(slot_adr(10), 32'h87); wr(slot_adr(70), 32'h87);
    drive_chk("R5 line 10 alone", NREQ'(1) << 10);
    drive_chk("R5 line 70 alone", NREQ'(1) << 70);
    drive_chk("R5 both lines", (NREQ'(1) << 10) | (NREQ'(1) << 70));
    chk("R5 ch7 raised", 32'(chan_req), 32'h80);

    // R6: disabled entry and clearing
    wr(slot_adr(20), 32'h1F);
    req_in = NREQ'(1) << 20; #1; chk("R6 disabled entry", 32'(chan_req), 32'd0);
    wr(slot_adr(3), 32'h0);
    req_in = NREQ'(1) << 3;  #1; chk("R6 zero write unmaps", 32'(chan_req), 32'd0);

    // R7: status word
    req_in = (NREQ'(1) << 66) | (NREQ'(1) << 10);
    rd(16'h0000, d); chk("R7 status", d, 32'h1080);
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, d); chk("R7 status after write", d, 32'h1080);
    rd(slot_adr(66), d); chk("R7 write left entries", d, 32'h8C);

    // R8: unimplemented offsets
    wr(16'h1140, 32'h85); rd(16'h1140, d); chk("R8 beyond NUM_REQ", d, 32'h0);
    wr(16'h010E, 32'h80); rd(16'h010E, d); chk("R8 misaligned", d, 32'h0);
    rd(slot_adr(3), d); chk("R8 misaligned write ignored", d, 32'h0);
    rd(16'h0200, d); chk("R8 gap address", d, 32'h0);
    drive_chk("R8 routing unchanged", '1);

    // random mix: R2 R4 R5 R6
    for (int i = 0; i < 400; i++) begin
      int n = int'($urandom % NREQ);
      wr(slot_adr(n), $urandom & 32'hFF);
      rq = {$urandom, $urandom, $urandom};
      drive_chk("R4 random routing", rq);
      if (i % 5 == 0) begin
        int k = int'($urandom % NREQ);
        rd(slot_adr(k), d); chk("R2 random readback", d, model_word(k));
      end
      if (i % 7 == 0) begin
        rd(16'h0000, d); chk("R7 random status", d, 32'(model_route(rq)));
      end
    end
    finish_run();
  end
endmodule